// File: doc/BRIEF.md
# SPI Burst Transfer Sequencer

This block drains 32-bit words from an external transmit FIFO and shifts them out as SPI bursts whose length, counted in bits, comes from a configuration field. Every word goes out in bytes, lowest byte first. Within each byte the bits go out most-significant first in SPI mode 0: SCLK idles low, MOSI is stable on the rising edge, and MISO is sampled on the rising edge. The received bytes are packed little-endian into a 32-bit word. That word is pushed to an external receive FIFO once the last byte belonging to the word has arrived.

A burst can be longer than one word. In that case it keeps popping words until its bit budget runs out. When a burst ends, the sequencer clears its exchange flag. What happens next depends on multiple-burst mode. If the mode is off, the sequencer reports transfer-complete and stops, even when words remain in the FIFO. If the mode is on, the next word opens a fresh burst and sets the exchange flag again. A transfer starts in one of two ways. In immediate-start mode, a write to the transmit FIFO starts it. Otherwise, a software write that takes the exchange flag from 0 to 1 starts it. One of four active-low chip selects is driven low whenever the selected channel is configured as master.

Top module: `spi_burst_seq`

## Requirements
- R1: A burst is `cfg_blen + 1` bits long. Each popped word sends ceil(min(remaining, 32) / 8) bytes, and every byte sent lowers the remaining count by 8 (so 12 bits give 2 bytes).
- R2: SCLK idles low. Each SCLK half period lasts `cfg_half_div + 1` system clocks. MOSI carries bit 7 of the byte first.
- R3: Bits 7:0 of a word are sent first. Received byte k lands in bits 8k+7:8k, and unused upper bytes read zero. The word is pushed with `rx_push` after its last byte.
- R4: One burst continues over several FIFO words. A new burst length is loaded only when the remaining count is zero or negative.
- R5: If `rx_full` is high when a word completes, the word is dropped and `ovf_pulse` pulses for one cycle.
- R6: Multiple-burst mode applies when the selected channel is master, `cfg_imm` is 0 and `cfg_wave[cfg_sel]` is 1. In this mode `xch_bit` is set at the start of every burst and sequencing continues past burst ends.
- R7: At a burst end `xch_bit` clears. Outside multiple-burst mode, `tc_pulse` then pulses and no further word is popped.
- R8: `tc_pulse` also pulses when the transmit FIFO is empty at the end of a word. A multiple-burst run produces exactly one pulse.
- R9: With `cfg_imm` = 1, `tx_wr` starts a transfer. With `cfg_imm` = 0, `xch_wr` while `xch_bit` = 0 starts one, and `tx_wr` alone does not. Nothing starts unless `cfg_master[cfg_sel]` = 1.
- R10: `cs_n[i]` is 0 only for i = `cfg_sel` with that channel master. Every other chip select is 1, and all are 1 when the channel is not master. The outputs are registered, so they follow the configuration one clock later.
- R11: During reset `cs_n` = 4'b1111, `sclk` = 0, `xch_bit` = 0, and `tx_pop` = `rx_push` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_blen | input | BLEN_W | Burst length minus one, in bits |
| cfg_sel | input | SEL_W | Selected channel |
| cfg_master | input | NCH | Per-channel master enable |
| cfg_imm | input | 1 | Immediate-start mode |
| cfg_wave | input | NCH | Per-channel multiple-burst enable |
| cfg_half_div | input | DIV_W | SCLK half period minus one, in system clocks |
| xch_wr | input | 1 | Software write setting the exchange flag |
| tx_wr | input | 1 | Pulse: a word was written to the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_data | input | 32 | Transmit FIFO head word |
| tx_pop | output | 1 | Pop the transmit FIFO head |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Push `rx_data` into the receive FIFO |
| rx_data | output | 32 | Assembled receive word |
| xch_bit | output | 1 | Exchange flag |
| tc_pulse | output | 1 | Transfer-complete event |
| ovf_pulse | output | 1 | Receive-overflow event |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCH | Active-low chip selects |

## Verification
The assertions assume that the transmit FIFO keeps `tx_valid` and `tx_data` coherent with `tx_pop`: a pop is honoured on the next edge and the head word stays stable otherwise. They also assume that the configuration fields do not change while a transfer runs. The bench models the FIFO with two pointers and changes configuration only after `tc_pulse` has been seen. It drives every input away from the active clock edge, and its slave model returns MISO bytes from a counting pattern.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOAD  = 3'd1,
    S_BGO   = 3'd2,
    S_BWAIT = 3'd3,
    S_WEND  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             done,
  output logic [7:0]       rx_byte
);
  logic             busy_q, busy_d, sclk_q, sclk_d, done_q, done_d;
  logic [7:0]       sh_q, sh_d, rx_q, rx_d;
  logic [2:0]       bit_q, bit_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign tick = busy_q && (cnt_q == half_div);

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      sh_d   = tx_byte;
      bit_d  = 3'd0;
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (busy_q) begin
      if (tick) begin
        cnt_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], miso};
        end else begin
          sclk_d = 1'b0;
          if (bit_q == 3'd7) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
            sh_d  = {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = sh_q[7];
  assign done    = done_q;
  assign rx_byte = rx_q;

  // R2: the clock rests low whenever no byte is in flight
  p_sclk_rest_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q);
  // R2: a byte completes only out of an active shift
  p_done_from_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));
endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
  parameter  int NCH   = 4,
  localparam int SEL_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [NCH-1:0]   master,
  output logic [NCH-1:0]   cs_n
);
  logic [NCH-1:0] cs_d, cs_q;

  for (genvar i = 0; i < NCH; i++) begin : g_cs
    assign cs_d[i] = !(master[sel] && (sel == SEL_W'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= '1;
    else        cs_q <= cs_d;
  end

  assign cs_n = cs_q;

  // R10: at most one chip select is active
  p_cs_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_q) <= 1);
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_seq_pkg::*;
#(
  parameter  int BLEN_W = 12,
  parameter  int NCH    = 4,
  localparam int SEL_W  = $clog2(NCH),
  localparam int REM_W  = BLEN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLEN_W-1:0] cfg_blen,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [NCH-1:0]    cfg_master,
  input  logic              cfg_imm,
  input  logic [NCH-1:0]    cfg_wave,
  input  logic              xch_wr,
  input  logic              tx_wr,
  input  logic              tx_valid,
  input  logic [31:0]       tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [31:0]       rx_data,
  output logic              xch_bit,
  output logic              tc_pulse,
  output logic              ovf_pulse,
  output logic              sh_start,
  output logic [7:0]        sh_byte,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx
);
  seq_state_t               state_q, state_d;
  logic signed [REM_W-1:0]  rem_q, rem_d, full_len, eff_len;
  logic [REM_W-1:0]         eff_u;
  logic [31:0]              wsh_q, wsh_d, rxw_q, rxw_d;
  logic [1:0]               bidx_q, bidx_d, last_q, last_d;
  logic                     xch_q, xch_d;
  logic                     mst, multi, trig;
  logic [5:0]               lim;
  logic [2:0]               nbytes;

  assign mst      = cfg_master[cfg_sel];
  assign multi    = mst && !cfg_imm && cfg_wave[cfg_sel];
  assign trig     = mst && ((cfg_imm && tx_wr) || (!cfg_imm && xch_wr && !xch_q));
  assign full_len = $signed({2'b00, cfg_blen} + REM_W'(1));
  assign eff_len  = (rem_q <= 0) ? full_len : rem_q;
  assign eff_u    = eff_len;
  assign lim      = (eff_u > REM_W'(32)) ? 6'd32 : eff_u[5:0];
  assign nbytes   = 3'((lim + 6'd7) >> 3);

  always_comb begin
    state_d   = state_q;
    rem_d     = rem_q;
    wsh_d     = wsh_q;
    rxw_d     = rxw_q;
    bidx_d    = bidx_q;
    last_d    = last_q;
    xch_d     = xch_q;
    tx_pop    = 1'b0;
    rx_push   = 1'b0;
    tc_pulse  = 1'b0;
    ovf_pulse = 1'b0;
    sh_start  = 1'b0;
    if (xch_wr) xch_d = 1'b1;
    unique case (state_q)
      S_IDLE: if (trig) state_d = S_LOAD;
      S_LOAD: begin
        if (!tx_valid) begin
          tc_pulse = 1'b1;
          state_d  = S_IDLE;
        end else begin
          if (rem_q <= 0) begin
            rem_d = full_len;
            if (multi) xch_d = 1'b1;
          end
          tx_pop  = 1'b1;
          wsh_d   = tx_data;
          rxw_d   = '0;
          bidx_d  = 2'd0;
          last_d  = 2'(nbytes - 3'd1);
          state_d = S_BGO;
        end
      end
      S_BGO: begin
        sh_start = 1'b1;
        state_d  = S_BWAIT;
      end
      S_BWAIT: if (sh_done) begin
        rxw_d[bidx_q*8 +: 8] = sh_rx;
        wsh_d = {8'h00, wsh_q[31:8]};
        rem_d = rem_q - REM_W'(8);
        if (bidx_q == last_q) state_d = S_WEND;
        else begin
          bidx_d  = bidx_q + 2'd1;
          state_d = S_BGO;
        end
      end
      S_WEND: begin
        if (rx_full) ovf_pulse = 1'b1;
        else         rx_push   = 1'b1;
        if (rem_q <= 0) xch_d = 1'b0;
        if ((rem_q <= 0 && !multi) || !tx_valid) begin
          tc_pulse = 1'b1;
          state_d  = S_IDLE;
        end else begin
          state_d = S_LOAD;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rem_q   <= '0;
      wsh_q   <= '0;
      rxw_q   <= '0;
      bidx_q  <= '0;
      last_q  <= '0;
      xch_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      wsh_q   <= wsh_d;
      rxw_q   <= rxw_d;
      bidx_q  <= bidx_d;
      last_q  <= last_d;
      xch_q   <= xch_d;
    end
  end

  assign rx_data = rxw_q;
  assign xch_bit = xch_q;
  assign sh_byte = wsh_q[7:0];

  // R4: a word is taken only when the FIFO offers one
  p_pop_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid);
  // R5: never push into a full receive FIFO
  p_push_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
  // R5: a finished word is either stored or reported lost, not both
  p_push_or_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_push && ovf_pulse));
  // R7: completion leaves the sequencer idle
  p_tc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> (state_q == S_IDLE));
  // R7: the exchange flag falls only at the end of a word
  p_xch_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xch_q) |-> ($past(state_q) == S_WEND));
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq #(
  parameter  int BLEN_W = 12,
  parameter  int DIV_W  = 8,
  parameter  int NCH    = 4,
  localparam int SEL_W  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLEN_W-1:0] cfg_blen,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [NCH-1:0]    cfg_master,
  input  logic              cfg_imm,
  input  logic [NCH-1:0]    cfg_wave,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic              xch_wr,
  input  logic              tx_wr,
  input  logic              tx_valid,
  input  logic [31:0]       tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [31:0]       rx_data,
  output logic              xch_bit,
  output logic              tc_pulse,
  output logic              ovf_pulse,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCH-1:0]    cs_n
);
  logic       sh_start, sh_done;
  logic [7:0] sh_byte, sh_rx;

  spi_burst_ctrl #(.BLEN_W(BLEN_W), .NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_blen(cfg_blen), .cfg_sel(cfg_sel),
    .cfg_master(cfg_master), .cfg_imm(cfg_imm), .cfg_wave(cfg_wave),
    .xch_wr(xch_wr), .tx_wr(tx_wr), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
    .xch_bit(xch_bit), .tc_pulse(tc_pulse), .ovf_pulse(ovf_pulse),
    .sh_start(sh_start), .sh_byte(sh_byte), .sh_done(sh_done), .sh_rx(sh_rx)
  );

  spi_byte_shift #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .half_div(cfg_half_div), .start(sh_start),
    .tx_byte(sh_byte), .miso(miso), .sclk(sclk), .mosi(mosi),
    .done(sh_done), .rx_byte(sh_rx)
  );

  spi_cs_decode #(.NCH(NCH)) u_cs (
    .clk(clk), .rst_n(rst_n), .sel(cfg_sel), .master(cfg_master), .cs_n(cs_n)
  );
endmodule

// File: tb/sim_spi_burst_seq.sv
module sim_spi_burst_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] cfg_blen;
  logic [1:0]  cfg_sel;
  logic [3:0]  cfg_master, cfg_wave, cs_n;
  logic        cfg_imm, xch_wr, tx_wr, tx_valid, tx_pop, rx_full, rx_push;
  logic [7:0]  cfg_half_div;
  logic [31:0] tx_data, rx_data;
  logic        xch_bit, tc_pulse, ovf_pulse, sclk, mosi, miso;

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // transmit FIFO model
  logic [31:0] txm [0:7];
  int unsigned wp = 0, rp;
  assign tx_valid = (wp != rp);
  assign tx_data  = txm[rp[2:0]];
  always @(posedge clk or negedge rst_n)
    if (!rst_n) rp <= 0;
    else if (tx_pop) rp <= rp + 1;

  // slave model: byte n answers 8'h30 + n, MSB first, mode 0
  logic [2:0] sb = 3'd0;
  int         sidx = 0;
  logic [7:0] slv_byte;
  assign slv_byte = 8'h30 + 8'(sidx);
  assign miso = slv_byte[3'd7 - sb];
  always @(negedge sclk) begin
    if (sb == 3'd7) sidx <= sidx + 1;
    sb <= sb + 3'd1;
  end

  spi_burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_blen(cfg_blen), .cfg_sel(cfg_sel),
    .cfg_master(cfg_master), .cfg_imm(cfg_imm), .cfg_wave(cfg_wave),
    .cfg_half_div(cfg_half_div), .xch_wr(xch_wr), .tx_wr(tx_wr),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full),
    .rx_push(rx_push), .rx_data(rx_data), .xch_bit(xch_bit),
    .tc_pulse(tc_pulse), .ovf_pulse(ovf_pulse), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0]  exp_mo[$];
  logic [31:0] exp_rx[$];
  int esidx = 0;
  int tc_cnt = 0, ovf_cnt = 0, pop_cnt = 0, xfall_cnt = 0;
  logic xch_prev = 1'b0;

  logic [7:0] mbyte = 8'h00;
  int mbits = 0;
  always @(posedge sclk) begin
    mbyte = {mbyte[6:0], mosi};
    mbits++;
    if (mbits == 8) begin
      mbits = 0;
      if (exp_mo.size() == 0) chk(1'b0, "R3 unexpected MOSI byte", {24'h0, mbyte}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_mo.pop_front();
        chk(mbyte == e, "R2/R3 MOSI byte order", {24'h0, mbyte}, {24'h0, e});
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (rx_push) begin
      if (exp_rx.size() == 0) chk(1'b0, "R5 unexpected rx_push", rx_data, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_rx.pop_front();
        chk(rx_data == e, "R3 received word packing", rx_data, e);
      end
    end
    if (tc_pulse) tc_cnt++;
    if (ovf_pulse) ovf_cnt++;
    if (tx_pop) pop_cnt++;
    if (xch_prev && !xch_bit) xfall_cnt++;
    xch_prev = xch_bit;
  end

  task automatic expect_word(input logic [31:0] w, input int nb, input bit keep);
    logic [31:0] r = 32'h0;
    for (int k = 0; k < nb; k++) begin
      exp_mo.push_back(w[8*k +: 8]);
      r[8*k +: 8] = 8'h30 + 8'(esidx);
      esidx++;
    end
    if (keep) exp_rx.push_back(r);
  endtask

  task automatic push_word(input logic [31:0] w, input bit wr);
    @(negedge clk);
    txm[wp[2:0]] = w;
    wp++;
    tx_wr = wr;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic pulse_xch();
    @(negedge clk); xch_wr = 1'b1;
    @(negedge clk); xch_wr = 1'b0;
  endtask

  task automatic wait_tc(input int target);
    for (int i = 0; i < 20000 && tc_cnt < target; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0, f0, r0;
    rst_n = 1'b0; cfg_blen = 12'd31; cfg_sel = 2'd0; cfg_master = 4'b1111;
    cfg_imm = 1'b1; cfg_wave = 4'b0000; cfg_half_div = 8'd1;
    xch_wr = 1'b0; tx_wr = 1'b0; rx_full = 1'b0;
    idle(3);
    // R11 reset state
    chk(cs_n == 4'b1111, "R11 cs_n in reset", {28'h0, cs_n}, 32'hF);
    chk(!sclk && !xch_bit && !tx_pop && !rx_push, "R11 outputs in reset",
        {28'h0, sclk, xch_bit, tx_pop, rx_push}, 32'h0);
    rst_n = 1'b1;
    idle(2);
    chk(cs_n == 4'b1110, "R10 cs_n channel 0", {28'h0, cs_n}, 32'hE);

    // R1 R3 R9: 32-bit burst, immediate start
    expect_word(32'h11223344, 4, 1'b1);
    push_word(32'h11223344, 1'b1);
    wait_tc(1);
    chk(tc_cnt == 1 && pop_cnt == 1, "R8 tc after single word", tc_cnt, 1);

    // R1: 12-bit burst gives two bytes
    cfg_blen = 12'd11;
    expect_word(32'hAABBCCDD, 2, 1'b1);
    push_word(32'hAABBCCDD, 1'b1);
    wait_tc(2);
    chk(tc_cnt == 2, "R1 12-bit burst complete", tc_cnt, 2);

    // R4 R9: 64-bit burst over two words, exchange start
    cfg_blen = 12'd63; cfg_imm = 1'b0;
    push_word(32'h01020304, 1'b1);
    push_word(32'h05060708, 1'b1);
    idle(200);
    chk(pop_cnt == 2, "R9 tx_wr ignored when immediate mode off", pop_cnt, 2);
    expect_word(32'h01020304, 4, 1'b1);
    expect_word(32'h05060708, 4, 1'b1);
    pulse_xch();
    chk(xch_bit == 1'b1, "R9 exchange flag set", {31'h0, xch_bit}, 1);
    wait_tc(3);
    chk(pop_cnt == 4 && tc_cnt == 3, "R4 burst spans two words", pop_cnt, 4);
    chk(xch_bit == 1'b0, "R7 exchange cleared at burst end", {31'h0, xch_bit}, 0);

    // R7: single-burst mode stops with data left
    cfg_blen = 12'd31;
    push_word(32'hA0A1A2A3, 1'b0);
    push_word(32'hB0B1B2B3, 1'b0);
    push_word(32'hC0C1C2C3, 1'b0);
    expect_word(32'hA0A1A2A3, 4, 1'b1);
    pulse_xch();
    wait_tc(4);
    idle(300);
    chk(wp - rp == 2, "R7 stop with two words left", wp - rp, 2);
    chk(tc_cnt == 4, "R7 tc on burst end", tc_cnt, 4);
    expect_word(32'hB0B1B2B3, 4, 1'b1);
    pulse_xch();
    wait_tc(5);
    expect_word(32'hC0C1C2C3, 4, 1'b1);
    pulse_xch();
    wait_tc(6);
    chk(wp == rp, "R7 remaining words drained", wp - rp, 0);

    // R6 R8: multiple-burst mode runs on across bursts
    cfg_wave = 4'b0001;
    f0 = xfall_cnt;
    push_word(32'hD0D1D2D3, 1'b0);
    push_word(32'hE0E1E2E3, 1'b0);
    expect_word(32'hD0D1D2D3, 4, 1'b1);
    expect_word(32'hE0E1E2E3, 4, 1'b1);
    pulse_xch();
    wait_tc(7);
    idle(100);
    chk(wp == rp && tc_cnt == 7, "R8 one tc for multi-burst run", tc_cnt, 7);
    chk(xfall_cnt - f0 == 2, "R6 exchange re-set per burst", xfall_cnt - f0, 2);
    cfg_wave = 4'b0000;

    // R5: overflow drops the word
    cfg_imm = 1'b1; rx_full = 1'b1;
    expect_word(32'h99887766, 4, 1'b0);
    push_word(32'h99887766, 1'b1);
    wait_tc(8);
    chk(ovf_cnt == 1, "R5 overflow pulse", ovf_cnt, 1);
    rx_full = 1'b0;

    // R10 R9: channel selection and non-master start
    cfg_sel = 2'd2;
    idle(2);
    chk(cs_n == 4'b1011, "R10 cs_n channel 2", {28'h0, cs_n}, 32'hB);
    cfg_master = 4'b1011;
    idle(2);
    chk(cs_n == 4'b1111, "R10 non-master keeps cs high", {28'h0, cs_n}, 32'hF);
    p0 = pop_cnt;
    push_word(32'h5A5A5A5A, 1'b1);
    idle(300);
    chk(pop_cnt == p0, "R9 no start when not master", pop_cnt, p0);
    cfg_master = 4'b1111;
    expect_word(32'h5A5A5A5A, 4, 1'b1);
    @(negedge clk); tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    wait_tc(9);

    // R2: SCLK period with half divider 2
    cfg_half_div = 8'd2; cfg_blen = 12'd7;
    expect_word(32'h000000C3, 1, 1'b1);
    push_word(32'h000000C3, 1'b1);
    begin
      logic pv = sclk;
      int n = 0;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (!pv && sclk) break;
        pv = sclk;
      end
      pv = sclk;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        n++;
        if (!pv && sclk) break;
        pv = sclk;
      end
      chk(n == 6, "R2 SCLK period", n, 6);
    end
    wait_tc(10);
    r0 = exp_rx.size();
    chk(exp_mo.size() == 0 && r0 == 0, "R3 scoreboard drained",
        exp_mo.size() + r0, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule